// File: doc/BRIEF.md
# Boot-Block Flash Program/Erase Sequencer

This block fronts a small nonvolatile array model with seven independently erasable blocks. A host presents one request at a time on a strobe-qualified command interface: program a location, erase a block, suspend or resume an erase, or clear the error flags. The block checks the protection conditions when it accepts a request. It then runs an internal sequencer. Programming repeats until the readback matches, up to a bounded number of attempts. An erase first drives every cell of the block to zero and then applies erase pulses until the whole block reads blank.

The array model is digital only. Programming can clear bits but never set them, and an erase sets every bit of one block. The simulated cells need `ERASE_NEED` pulses before they go blank, so an erase spans several attempts and a suspend can land between two attempts. One block is the boot block. A parameter places it at the lowest or the highest block index. It can be changed only while a hardware unlock input or the write-protect input is high. The host polls an 8-bit status word. Two of its flags belong to the sequencer, and three sticky error flags stay set until the host clears them.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the status word reads 0x80 and every array word reads all ones.
- R2: An accepted word-mode program (cmdOp 1) leaves each cell equal to its old value ANDed with the data. When the verify matches on the first attempt, busy (status bit 7 low) lasts exactly 2 cycles.
- R3: When the readback cannot match, the sequencer makes MAX_TRIES attempts of 2 cycles each. It then clears busy and sets the write-error flag (status bit 4).
- R4: With wordMode low, addresses count bytes: bit 0 picks the high byte. A program touches only the addressed byte, and a read returns that byte zero-extended.
- R5: An erase (cmdOp 2) leaves every word of the addressed block all ones and leaves all other blocks unchanged.
- R6: A program or erase of the boot block (block 6 by default) is refused unless bootUnlock or wpHigh is high. A refusal sets the write-error flag or the erase-error flag (status bit 5), sets no busy and leaves the array unchanged.
- R7: With vppOk low, a program or erase is refused. The refusal sets the supply-fault flag (status bit 3) together with that operation's error flag.
- R8: Error flags stay set through later successful operations. Only a clear request (cmdOp 5) clears them, and it leaves the ready bit set.
- R9: A suspend request (cmdOp 3) made during an erase takes effect at the next failed erase verify. The suspended flag (bit 6) and ready then read 0xC0. Program and erase requests are ignored while suspended. A resume (cmdOp 4) continues from the saved attempt count. A suspend made while idle has no effect.
- R10: A suspend that arrives in the same cycle as the erase verify that passes is dropped. The erase completes and the status word reads 0x80.
- R11: An uninterrupted erase keeps busy for BLOCK_WORDS + 2*ERASE_NEED cycles: 14 cycles with the default parameters.
- R12: A program or erase addressed to block index 7, which does not exist, is refused and sets that operation's error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bootUnlock | input | 1 | Elevated-voltage unlock condition for the boot block |
| wpHigh | input | 1 | Write-protect input; high unlocks the boot block |
| vppOk | input | 1 | Programming supply valid |
| wordMode | input | 1 | 1 = 16-bit words, 0 = bytes |
| cmdValid | input | 1 | Command strobe, one cycle per request |
| cmdOp | input | 3 | 1 program, 2 erase, 3 suspend, 4 resume, 5 clear errors |
| cmdAddr | input | 7 | Word address {block, offset}; in byte mode a byte address |
| cmdData | input | 16 | Program data; only the low byte is used in byte mode |
| rdAddr | input | 7 | Read address, interpreted like cmdAddr |
| rdData | output | 16 | Array read data, zero-extended byte in byte mode |
| status | output | 8 | {ready, suspended, eraseErr, writeErr, supplyFault, 3'b000} |

## Verification
A suspend request and an erase attempt boundary can fall on the same clock edge. The bench places the suspend strobe exactly on the cycle of a failing verify and checks that the status word reads 0xC0 on the next cycle. It repeats the suspend while the block is still being pre-programmed and checks that the pending request waits for that same boundary. It also places the strobe on the cycle of the final, passing verify and checks that the status word reads 0x80 and the block is blank. After each resume, the bench times the remaining busy window to confirm that the attempt count was kept.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_PROGRAM = 3'd1,
    OP_ERASE   = 3'd2,
    OP_SUSPEND = 3'd3,
    OP_RESUME  = 3'd4,
    OP_CLEAR   = 3'd5
  } hostOp_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WR_PROG,
    SQ_WR_VERIFY,
    SQ_ER_PRE,
    SQ_ER_PULSE,
    SQ_ER_VERIFY,
    SQ_SUSPENDED
  } seqState_e;

  // Strobes from the sequencer to the cell array.
  typedef struct packed {
    logic progWord;
    logic preProg;
    logic erasePulse;
  } arrayStrobe_t;

  localparam int ST_READY   = 7;
  localparam int ST_SUSP    = 6;
  localparam int ST_ER_ERR  = 5;
  localparam int ST_WR_ERR  = 4;
  localparam int ST_VPP_ERR = 3;

endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS  = 7,
  parameter int BLOCK_WORDS = 8,
  parameter int DATA_W      = 16,
  parameter int ERASE_NEED  = 3,
  parameter int BLK_W       = 3,
  parameter int OFF_W       = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  arrayStrobe_t           strobe,
  input  logic [BLK_W-1:0]       opBlk,
  input  logic [OFF_W-1:0]       opOff,
  input  logic [DATA_W-1:0]      opData,
  input  logic [DATA_W-1:0]      opMask,
  input  logic                   wordMode,
  input  logic [BLK_W+OFF_W:0]   rdAddr,
  output logic [DATA_W-1:0]      rdData,
  output logic                   cellMatch,
  output logic                   blockBlank
);

  localparam int ADDR_W  = BLK_W + OFF_W;
  localparam int HALF    = DATA_W / 2;
  localparam int PULSE_W = $clog2(ERASE_NEED + 1);
  localparam logic [PULSE_W-1:0] FIRE_AT = PULSE_W'(ERASE_NEED - 1);

  logic [DATA_W-1:0]     blkRd    [NUM_BLOCKS];
  logic [DATA_W-1:0]     blkOp    [NUM_BLOCKS];
  logic [NUM_BLOCKS-1:0] blkBlank;
  logic [PULSE_W-1:0]    pulseCnt;
  logic                  eraseFire;

  logic [ADDR_W-1:0] rdWordAddr;
  logic [BLK_W-1:0]  rdBlk;
  logic [OFF_W-1:0]  rdOff;
  logic              rdLaneHi;
  logic              rdInRange;
  logic              opInRange;
  logic [BLK_W-1:0]  rdSel;
  logic [BLK_W-1:0]  opSel;
  logic [DATA_W-1:0] rdWord;

  // Erase pulses accumulate on the cells; the block goes blank on pulse ERASE_NEED.
  assign eraseFire = strobe.erasePulse && (pulseCnt == FIRE_AT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strobe.preProg) begin
      pulseCnt <= '0;
    end else if (strobe.erasePulse && (pulseCnt != FIRE_AT)) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : gBlock
    logic [DATA_W-1:0] cells [BLOCK_WORDS];
    logic              hit;
    logic              blankHere;

    assign hit = (int'(opBlk) == b);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int w = 0; w < BLOCK_WORDS; w++) cells[w] <= '1;
      end else if (hit) begin
        if (strobe.progWord) cells[opOff] <= cells[opOff] & (opData | ~opMask);
        if (strobe.preProg)  cells[opOff] <= '0;
        if (eraseFire) begin
          for (int w = 0; w < BLOCK_WORDS; w++) cells[w] <= '1;
        end
      end
    end

    always_comb begin
      blankHere = 1'b1;
      for (int w = 0; w < BLOCK_WORDS; w++) blankHere = blankHere & (&cells[w]);
    end

    assign blkBlank[b] = blankHere;
    assign blkRd[b]    = cells[rdOff];
    assign blkOp[b]    = cells[opOff];
  end

  // Read path: byte mode shifts the address and picks a lane.
  assign rdWordAddr = wordMode ? rdAddr[ADDR_W-1:0] : rdAddr[ADDR_W:1];
  assign rdLaneHi   = !wordMode && rdAddr[0];
  assign rdBlk      = rdWordAddr[ADDR_W-1:OFF_W];
  assign rdOff      = rdWordAddr[OFF_W-1:0];
  assign rdInRange  = int'(rdBlk) < NUM_BLOCKS;
  assign rdSel      = rdInRange ? rdBlk : '0;
  assign rdWord     = rdInRange ? blkRd[rdSel] : '1;

  always_comb begin
    if (wordMode)      rdData = rdWord;
    else if (rdLaneHi) rdData = {{HALF{1'b0}}, rdWord[DATA_W-1:HALF]};
    else               rdData = {{HALF{1'b0}}, rdWord[HALF-1:0]};
  end

  assign opInRange  = int'(opBlk) < NUM_BLOCKS;
  assign opSel      = opInRange ? opBlk : '0;
  assign cellMatch  = (blkOp[opSel] & opMask) == (opData & opMask);
  assign blockBlank = blkBlank[opSel];

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS  = 7,
  parameter int BLOCK_WORDS = 8,
  parameter int DATA_W      = 16,
  parameter int MAX_TRIES   = 16,
  parameter int BOOT_BLK    = 6,
  parameter int BLK_W       = 3,
  parameter int OFF_W       = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 bootUnlock,
  input  logic                 wpHigh,
  input  logic                 vppOk,
  input  logic                 wordMode,
  input  logic                 cmdValid,
  input  logic [2:0]           cmdOp,
  input  logic [BLK_W+OFF_W:0] cmdAddr,
  input  logic [DATA_W-1:0]    cmdData,
  input  logic                 cellMatch,
  input  logic                 blockBlank,
  output arrayStrobe_t         strobe,
  output logic [BLK_W-1:0]     opBlk,
  output logic [OFF_W-1:0]     opOff,
  output logic [DATA_W-1:0]    opData,
  output logic [DATA_W-1:0]    opMask,
  output logic [7:0]           status
);

  localparam int ADDR_W = BLK_W + OFF_W;
  localparam int HALF   = DATA_W / 2;
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [TRY_W-1:0] LAST_TRY = TRY_W'(MAX_TRIES - 1);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(BLOCK_WORDS - 1);

  seqState_e         state;
  hostOp_e           opIn;
  logic [TRY_W-1:0]  tries;
  logic              suspPend;
  logic [2:0]        errs;      // {erase, write, supply}
  logic [2:0]        errSet;

  logic [ADDR_W-1:0] wordAddr;
  logic              laneHi;
  logic [BLK_W-1:0]  reqBlk;
  logic [OFF_W-1:0]  reqOff;
  logic [DATA_W-1:0] reqData;
  logic [DATA_W-1:0] reqMask;
  logic              blkOk;
  logic              protOk;
  logic              isProg;
  logic              isErase;
  logic              suspReq;
  logic              resumeReq;
  logic              clearReq;
  logic              startOk;

  assign opIn      = hostOp_e'(cmdOp);
  assign isProg    = cmdValid && (opIn == OP_PROGRAM);
  assign isErase   = cmdValid && (opIn == OP_ERASE);
  assign suspReq   = cmdValid && (opIn == OP_SUSPEND);
  assign resumeReq = cmdValid && (opIn == OP_RESUME);
  assign clearReq  = cmdValid && (opIn == OP_CLEAR);

  // Request decode: byte mode uses bit 0 as the lane select.
  assign wordAddr = wordMode ? cmdAddr[ADDR_W-1:0] : cmdAddr[ADDR_W:1];
  assign laneHi   = !wordMode && cmdAddr[0];
  assign reqBlk   = wordAddr[ADDR_W-1:OFF_W];
  assign reqOff   = wordAddr[OFF_W-1:0];

  always_comb begin
    if (wordMode) begin
      reqData = cmdData;
      reqMask = '1;
    end else if (laneHi) begin
      reqData = {cmdData[HALF-1:0], {HALF{1'b1}}};
      reqMask = {{HALF{1'b1}}, {HALF{1'b0}}};
    end else begin
      reqData = {{HALF{1'b1}}, cmdData[HALF-1:0]};
      reqMask = {{HALF{1'b0}}, {HALF{1'b1}}};
    end
  end

  assign blkOk   = int'(reqBlk) < NUM_BLOCKS;
  assign protOk  = blkOk && ((int'(reqBlk) != BOOT_BLK) || bootUnlock || wpHigh);
  assign startOk = vppOk && protOk;

  always_comb begin
    errSet = '0;
    if (state == SQ_IDLE && (isProg || isErase) && !startOk) begin
      errSet[0] = !vppOk;
      errSet[1] = isProg;
      errSet[2] = isErase;
    end
    if (state == SQ_WR_VERIFY && !cellMatch && tries == LAST_TRY) errSet[1] = 1'b1;
    if (state == SQ_ER_VERIFY && !blockBlank && tries == LAST_TRY) errSet[2] = 1'b1;
  end

  always_comb begin
    strobe            = '0;
    strobe.progWord   = (state == SQ_WR_PROG);
    strobe.preProg    = (state == SQ_ER_PRE);
    strobe.erasePulse = (state == SQ_ER_PULSE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= SQ_IDLE;
      opBlk    <= '0;
      opOff    <= '0;
      opData   <= '0;
      opMask   <= '0;
      tries    <= '0;
      suspPend <= 1'b0;
      errs     <= '0;
    end else begin
      errs <= (clearReq ? 3'b000 : errs) | errSet;
      unique case (state)
        SQ_IDLE: begin
          if ((isProg || isErase) && startOk) begin
            opBlk    <= reqBlk;
            opOff    <= isErase ? '0 : reqOff;
            opData   <= reqData;
            opMask   <= reqMask;
            tries    <= '0;
            suspPend <= 1'b0;
            state    <= isErase ? SQ_ER_PRE : SQ_WR_PROG;
          end
        end
        SQ_WR_PROG: state <= SQ_WR_VERIFY;
        SQ_WR_VERIFY: begin
          if (cellMatch || tries == LAST_TRY) begin
            state <= SQ_IDLE;
          end else begin
            tries <= tries + 1'b1;
            state <= SQ_WR_PROG;
          end
        end
        SQ_ER_PRE: begin
          if (suspReq) suspPend <= 1'b1;
          if (opOff == LAST_OFF) begin
            opOff <= '0;
            state <= SQ_ER_PULSE;
          end else begin
            opOff <= opOff + 1'b1;
          end
        end
        SQ_ER_PULSE: begin
          if (suspReq) suspPend <= 1'b1;
          state <= SQ_ER_VERIFY;
        end
        SQ_ER_VERIFY: begin
          if (blockBlank || tries == LAST_TRY) begin
            suspPend <= 1'b0;
            state    <= SQ_IDLE;
          end else begin
            tries <= tries + 1'b1;
            if (suspPend || suspReq) begin
              suspPend <= 1'b0;
              state    <= SQ_SUSPENDED;
            end else begin
              state <= SQ_ER_PULSE;
            end
          end
        end
        SQ_SUSPENDED: begin
          if (resumeReq) state <= SQ_ER_PULSE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    status              = '0;
    status[ST_READY]    = (state == SQ_IDLE) || (state == SQ_SUSPENDED);
    status[ST_SUSP]     = (state == SQ_SUSPENDED);
    status[ST_ER_ERR]   = errs[2];
    status[ST_WR_ERR]   = errs[1];
    status[ST_VPP_ERR]  = errs[0];
  end

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int NUM_BLOCKS  = 7,
  parameter int BLOCK_WORDS = 8,
  parameter int DATA_W      = 16,
  parameter int MAX_TRIES   = 16,
  parameter int ERASE_NEED  = 3,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input  logic                                               clk,
  input  logic                                               rstN,
  input  logic                                               bootUnlock,
  input  logic                                               wpHigh,
  input  logic                                               vppOk,
  input  logic                                               wordMode,
  input  logic                                               cmdValid,
  input  logic [2:0]                                         cmdOp,
  input  logic [$clog2(NUM_BLOCKS)+$clog2(BLOCK_WORDS):0]    cmdAddr,
  input  logic [DATA_W-1:0]                                  cmdData,
  input  logic [$clog2(NUM_BLOCKS)+$clog2(BLOCK_WORDS):0]    rdAddr,
  output logic [DATA_W-1:0]                                  rdData,
  output logic [7:0]                                         status
);

  localparam int BLK_W    = $clog2(NUM_BLOCKS);
  localparam int OFF_W    = $clog2(BLOCK_WORDS);
  localparam int BOOT_BLK = BOOT_AT_TOP ? NUM_BLOCKS - 1 : 0;

  arrayStrobe_t      strobe;
  logic [BLK_W-1:0]  opBlk;
  logic [OFF_W-1:0]  opOff;
  logic [DATA_W-1:0] opData;
  logic [DATA_W-1:0] opMask;
  logic              cellMatch;
  logic              blockBlank;

  flash_seq_ctrl #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .DATA_W     (DATA_W),
    .MAX_TRIES  (MAX_TRIES),
    .BOOT_BLK   (BOOT_BLK),
    .BLK_W      (BLK_W),
    .OFF_W      (OFF_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .bootUnlock(bootUnlock),
    .wpHigh    (wpHigh),
    .vppOk     (vppOk),
    .wordMode  (wordMode),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .cellMatch (cellMatch),
    .blockBlank(blockBlank),
    .strobe    (strobe),
    .opBlk     (opBlk),
    .opOff     (opOff),
    .opData    (opData),
    .opMask    (opMask),
    .status    (status)
  );

  flash_cell_array #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .BLOCK_WORDS(BLOCK_WORDS),
    .DATA_W     (DATA_W),
    .ERASE_NEED (ERASE_NEED),
    .BLK_W      (BLK_W),
    .OFF_W      (OFF_W)
  ) u_array (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opBlk     (opBlk),
    .opOff     (opOff),
    .opData    (opData),
    .opMask    (opMask),
    .wordMode  (wordMode),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .cellMatch (cellMatch),
    .blockBlank(blockBlank)
  );

endmodule

// File: rtl/flash_pe_checks.sv
module flash_pe_checks #(
  parameter int NUM_BLOCKS  = 7,
  parameter int BLOCK_WORDS = 8,
  parameter int DATA_W      = 16,
  parameter int MAX_TRIES   = 16,
  parameter int ERASE_NEED  = 3,
  parameter bit BOOT_AT_TOP = 1'b1
) (
  input logic                                            clk,
  input logic                                            rstN,
  input logic                                            bootUnlock,
  input logic                                            wpHigh,
  input logic                                            vppOk,
  input logic                                            wordMode,
  input logic                                            cmdValid,
  input logic [2:0]                                      cmdOp,
  input logic [$clog2(NUM_BLOCKS)+$clog2(BLOCK_WORDS):0] cmdAddr,
  input logic [7:0]                                      status
);

  localparam int BLK_W    = $clog2(NUM_BLOCKS);
  localparam int OFF_W    = $clog2(BLOCK_WORDS);
  localparam int ADDR_W   = BLK_W + OFF_W;
  localparam int BOOT_BLK = BOOT_AT_TOP ? NUM_BLOCKS - 1 : 0;
  localparam int BUSY_MAX = BLOCK_WORDS + 2 * MAX_TRIES;

  logic        idle;
  logic        chgReq;
  logic [15:0] busyRun;

  assign idle   = status[7] && !status[6];
  assign chgReq = cmdValid && (cmdOp == 3'd1 || cmdOp == 3'd2);

  always_ff @(posedge clk) begin
    if (!rstN)           busyRun <= '0;
    else if (status[7])  busyRun <= '0;
    else if (busyRun != 16'hFFFF) busyRun <= busyRun + 1'b1;
  end

  // R3 / R11: no busy stretch outlasts the longest sequence.
  assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rstN)
    busyRun <= 16'(BUSY_MAX));

  // R9: a suspended sequencer always reports ready.
  assert_susp_ready_R9: assert property (@(posedge clk) disable iff (!rstN)
    status[6] |-> status[7]);

  // R9: suspension is entered only from a running erase.
  assert_susp_from_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[6]) |-> !$past(status[7]));

  // R8: error flags drop only after a clear request.
  assert_sticky_errors_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(status[3]) || $fell(status[4]) || $fell(status[5])) |->
      $past(cmdValid && cmdOp == 3'd5));

  // R7: a change request without a valid supply raises the supply fault.
  assert_supply_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chgReq && idle && !vppOk) |=> status[3]);

  // R6: a locked boot-block program in word mode is refused with the write flag.
  assert_boot_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 3'd1 && wordMode && idle && !bootUnlock && !wpHigh &&
     int'(cmdAddr[ADDR_W-1:OFF_W]) == BOOT_BLK) |=> (status[4] && status[7]));

endmodule

bind flash_pe_ctrl flash_pe_checks #(
  .NUM_BLOCKS (NUM_BLOCKS),
  .BLOCK_WORDS(BLOCK_WORDS),
  .DATA_W     (DATA_W),
  .MAX_TRIES  (MAX_TRIES),
  .ERASE_NEED (ERASE_NEED),
  .BOOT_AT_TOP(BOOT_AT_TOP)
) u_checks (
  .clk       (clk),
  .rstN      (rstN),
  .bootUnlock(bootUnlock),
  .wpHigh    (wpHigh),
  .vppOk     (vppOk),
  .wordMode  (wordMode),
  .cmdValid  (cmdValid),
  .cmdOp     (cmdOp),
  .cmdAddr   (cmdAddr),
  .status    (status)
);

// File: tb/test_flash_pe_ctrl.sv
`timescale 1ns/1ps
module test_flash_pe_ctrl;
  import flash_pe_pkg::*;

  localparam int NB = 7;
  localparam int BW = 8;
  localparam int DW = 16;
  localparam int MT = 16;
  localparam int EN = 3;
  localparam int AW = $clog2(NB) + $clog2(BW);

  logic          clk = 1'b0;
  logic          rstN;
  logic          bootUnlock, wpHigh, vppOk, wordMode, cmdValid;
  logic [2:0]    cmdOp;
  logic [AW:0]   cmdAddr, rdAddr;
  logic [DW-1:0] cmdData, rdData;
  logic [7:0]    status;

  always #2.5 clk = ~clk;

  flash_pe_ctrl #(.NUM_BLOCKS(NB), .BLOCK_WORDS(BW), .DATA_W(DW),
                  .MAX_TRIES(MT), .ERASE_NEED(EN), .BOOT_AT_TOP(1'b1))
  i_flash_pe_ctrl (
    .clk(clk), .rstN(rstN), .bootUnlock(bootUnlock), .wpHigh(wpHigh),
    .vppOk(vppOk), .wordMode(wordMode), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .rdAddr(rdAddr), .rdData(rdData),
    .status(status));

  typedef struct {
    logic [AW:0]   addr;
    logic [DW-1:0] exp;
    string         req;
  } rdItem_t;

  rdItem_t rdQ[$];
  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW:0] wAddr(int blk, int off);
    return (AW+1)'(blk * BW + off);
  endfunction

  // Driver side of the scoreboard.
  task automatic expectRead(logic [AW:0] a, logic [15:0] e, string req);
    rdItem_t it;
    it.addr = a; it.exp = e; it.req = req;
    rdQ.push_back(it);
  endtask

  task automatic drain();
    while (rdQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pops expected reads and compares against the array output.
  initial begin
    rdAddr = '0;
    forever begin
      rdItem_t it;
      @(negedge clk);
      if (rdQ.size() != 0) begin
        it = rdQ.pop_front();
        rdAddr = it.addr;
        #1;
        check(it.req, "read", rdData, it.exp);
      end
    end
  end

  // Drives one request for one cycle; returns at the negedge after acceptance.
  task automatic issue(hostOp_e op, logic [AW:0] a, logic [15:0] d);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = OP_NONE;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (status[7] !== 1'b1 && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #500000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int n;
    rstN = 1'b0; bootUnlock = 1'b0; wpHigh = 1'b0; vppOk = 1'b1; wordMode = 1'b1;
    cmdValid = 1'b0; cmdOp = OP_NONE; cmdAddr = '0; cmdData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "status", {8'h00, status}, 16'h0080);
    expectRead(wAddr(0, 0), 16'hFFFF, "R1");
    expectRead(wAddr(1, 5), 16'hFFFF, "R1");
    expectRead(wAddr(6, 7), 16'hFFFF, "R1");
    drain();

    // R2 word programs
    issue(OP_PROGRAM, wAddr(1, 2), 16'h1234);
    busyLen(n);
    check("R2", "busy cycles", 16'(n), 16'd2);
    issue(OP_PROGRAM, wAddr(1, 2), 16'h0204);
    busyLen(n);
    check("R2", "busy cycles", 16'(n), 16'd2);
    check("R2", "status", {8'h00, status}, 16'h0080);
    expectRead(wAddr(1, 2), 16'h0204, "R2");
    drain();

    // R3 unreachable value: MT attempts then failure
    issue(OP_PROGRAM, wAddr(1, 2), 16'h00FF);
    busyLen(n);
    check("R3", "busy cycles", 16'(n), 16'(2 * MT));
    check("R3", "status", {8'h00, status}, 16'h0090);
    expectRead(wAddr(1, 2), 16'h0004, "R3");
    drain();

    // R8 sticky through a good program, then clear
    issue(OP_PROGRAM, wAddr(1, 3), 16'h5555);
    busyLen(n);
    check("R8", "status sticky", {8'h00, status}, 16'h0090);
    issue(OP_CLEAR, '0, '0);
    check("R8", "status cleared", {8'h00, status}, 16'h0080);
    expectRead(wAddr(1, 3), 16'h5555, "R8");
    drain();

    // R4 byte mode
    wordMode = 1'b0;
    issue(OP_PROGRAM, (AW+1)'(2 * (2 * BW + 4) + 1), 16'h77AB);
    busyLen(n);
    check("R4", "busy cycles", 16'(n), 16'd2);
    expectRead((AW+1)'(2 * (2 * BW + 4) + 1), 16'h00AB, "R4");
    expectRead((AW+1)'(2 * (2 * BW + 4)), 16'h00FF, "R4");
    drain();
    wordMode = 1'b1;
    expectRead(wAddr(2, 4), 16'hABFF, "R4");
    drain();

    // R5 / R11 erase of block 1
    issue(OP_ERASE, wAddr(1, 0), '0);
    busyLen(n);
    check("R11", "erase busy cycles", 16'(n), 16'(BW + 2 * EN));
    check("R5", "status", {8'h00, status}, 16'h0080);
    expectRead(wAddr(1, 2), 16'hFFFF, "R5");
    expectRead(wAddr(1, 3), 16'hFFFF, "R5");
    expectRead(wAddr(2, 4), 16'hABFF, "R5");
    drain();

    // R6 boot block locked, then unlocked
    issue(OP_PROGRAM, wAddr(6, 0), 16'h0000);
    busyLen(n);
    check("R6", "refused busy", 16'(n), 16'd0);
    check("R6", "status", {8'h00, status}, 16'h0090);
    issue(OP_CLEAR, '0, '0);
    issue(OP_ERASE, wAddr(6, 0), '0);
    check("R6", "erase refused status", {8'h00, status}, 16'h00A0);
    issue(OP_CLEAR, '0, '0);
    expectRead(wAddr(6, 0), 16'hFFFF, "R6");
    drain();
    wpHigh = 1'b1;
    issue(OP_PROGRAM, wAddr(6, 0), 16'h0F0F);
    busyLen(n);
    check("R6", "wp busy", 16'(n), 16'd2);
    expectRead(wAddr(6, 0), 16'h0F0F, "R6");
    drain();
    wpHigh = 1'b0; bootUnlock = 1'b1;
    issue(OP_ERASE, wAddr(6, 0), '0);
    busyLen(n);
    check("R6", "unlock erase busy", 16'(n), 16'(BW + 2 * EN));
    expectRead(wAddr(6, 0), 16'hFFFF, "R6");
    drain();
    bootUnlock = 1'b0;

    // R7 supply not valid
    vppOk = 1'b0;
    issue(OP_PROGRAM, wAddr(0, 0), 16'h0000);
    check("R7", "program status", {8'h00, status}, 16'h0098);
    issue(OP_CLEAR, '0, '0);
    issue(OP_ERASE, wAddr(0, 0), '0);
    check("R7", "erase status", {8'h00, status}, 16'h00A8);
    issue(OP_CLEAR, '0, '0);
    vppOk = 1'b1;
    expectRead(wAddr(0, 0), 16'hFFFF, "R7");
    drain();

    // R12 nonexistent block
    issue(OP_PROGRAM, wAddr(7, 0), 16'h0000);
    check("R12", "status", {8'h00, status}, 16'h0090);
    issue(OP_CLEAR, '0, '0);

    // R9 suspend while idle has no effect
    issue(OP_SUSPEND, '0, '0);
    check("R9", "idle suspend", {8'h00, status}, 16'h0080);

    // R9 suspend exactly on a failing verify
    issue(OP_ERASE, wAddr(3, 0), '0);
    repeat (9) @(negedge clk);
    cmdValid = 1'b1; cmdOp = OP_SUSPEND;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = OP_NONE;
    check("R9", "suspended status", {8'h00, status}, 16'h00C0);
    issue(OP_PROGRAM, wAddr(0, 0), 16'h0000);
    check("R9", "ignored while suspended", {8'h00, status}, 16'h00C0);
    expectRead(wAddr(0, 0), 16'hFFFF, "R9");
    drain();
    issue(OP_RESUME, '0, '0);
    busyLen(n);
    check("R9", "resume busy", 16'(n), 16'd4);
    check("R9", "after resume", {8'h00, status}, 16'h0080);
    expectRead(wAddr(3, 5), 16'hFFFF, "R9");
    drain();

    // R9 suspend during pre-programming waits for the boundary
    issue(OP_ERASE, wAddr(4, 0), '0);
    repeat (2) @(negedge clk);
    cmdValid = 1'b1; cmdOp = OP_SUSPEND;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = OP_NONE;
    repeat (6) @(negedge clk);
    check("R9", "pending still busy", {8'h00, status}, 16'h0000);
    @(negedge clk);
    check("R9", "pending suspended", {8'h00, status}, 16'h00C0);
    issue(OP_RESUME, '0, '0);
    busyLen(n);
    check("R9", "pending resume busy", 16'(n), 16'd4);

    // R10 suspend on the passing verify is dropped
    issue(OP_ERASE, wAddr(5, 0), '0);
    repeat (13) @(negedge clk);
    cmdValid = 1'b1; cmdOp = OP_SUSPEND;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = OP_NONE;
    check("R10", "status at completion", {8'h00, status}, 16'h0080);
    @(negedge clk);
    check("R10", "status after", {8'h00, status}, 16'h0080);
    expectRead(wAddr(5, 7), 16'hFFFF, "R10");
    drain();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule